// File: doc/BRIEF.md
# Low-Voltage Detect Control Register

This block is the 8-bit status and control register that sits beside a low-voltage comparator. Software configures the monitor through one byte-wide register port. The block records a sticky detect flag and turns a low-voltage event into either an interrupt request or a reset request. It also drives the enables for the comparator and the band-gap buffer. It has two reset inputs. A power-on reset clears everything. A system reset restores the configuration but keeps the detect flag, so software can find out after restart why the part went down.

Two of the enable bits, the monitor enable and the reset enable, lock after the first register write that follows any reset. The write-1 acknowledge removes the interrupt request at once. It clears the flag only when the supply has recovered at the moment of the write. When reset and interrupt are both enabled, the reset path wins. Test mode makes the stored reset enable act as 0.

Register byte as seen on `rd_data`: bit 7 detect flag (read only), bit 6 acknowledge (write only, reads 0), bit 5 interrupt enable, bit 4 reset enable, bit 3 stop enable, bit 2 monitor enable, bit 1 reserved (reads 0), bit 0 band-gap buffer enable.

Top module: `lvd_ctrl_reg`

## Requirements
- R1: After power-on reset, `rd_data` reads 0x1C (flag 0, interrupt enable 0, reset enable 1, stop enable 1, monitor enable 1, band-gap 0), `cmp_en` is 1 and both request outputs are 0.
- R2: The flag (bit 7) sets on the clock edge where `lv_det` is 1 while the comparator is enabled, and it stays 1 until it is acknowledged.
- R3: A write with bit 6 = 1 clears the flag at the next edge only if `lv_det` is 0 during that write; otherwise the flag stays 1. Bit 6 always reads 0.
- R4: `lvd_irq` is the flag AND interrupt enable AND monitor enable AND NOT effective reset enable. An acknowledge masks it until the flag has been cleared.
- R5: Monitor enable (bit 2) and reset enable (bit 4) take only the value of the first write after any reset. Later writes leave them unchanged.
- R6: With monitor enable 0, `cmp_en` is 0, the flag does not set and neither request output rises, whatever bits 5, 4 and 3 hold.
- R7: With monitor and reset enable set, `lvd_rst_req` is 1 in the cycle after an edge that sampled `lv_det` = 1, and `lvd_irq` stays 0 even when interrupt enable is 1.
- R8: While `test_mode` is 1, the reset enable acts as 0. No reset request is produced, and the interrupt path behaves as if reset enable were clear.
- R9: `cmp_en` goes to 0 while `stop_mode` is 1 and stop enable (bit 3) is 0. With stop enable 1, or outside stop mode, it follows monitor enable.
- R10: A system reset returns bits 5..0 to their power-on values and re-opens the write-once bits, but keeps the flag. Only power-on reset clears the flag.
- R11: Writes land on the clock edge that samples `wr_en`. Bit 1 always reads 0, and `bgbuf_en` follows bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| sys_rst_n | input | 1 | System reset, active low, asynchronous; keeps the flag |
| lv_det | input | 1 | Low-voltage comparator output, already synchronized to clk |
| stop_mode | input | 1 | Stop mode indicator |
| test_mode | input | 1 | Test mode indicator |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data byte |
| rd_data | output | 8 | Register read value |
| lvd_irq | output | 1 | Interrupt request, level |
| lvd_rst_req | output | 1 | Reset request to the reset controller |
| cmp_en | output | 1 | Comparator enable |
| bgbuf_en | output | 1 | Band-gap buffer enable |

## Verification
An acknowledge write and a live low-voltage detection can land in the same cycle. Detection then has to win for the flag, while the acknowledge still removes the interrupt request. The bench holds `lv_det` high through an acknowledge write and expects the flag to read back as 1 with `lvd_irq` at 0. After the supply recovers it repeats the acknowledge and expects the flag to clear, and then a fresh event must raise the interrupt again. A system reset that arrives while the flag is set is also checked: the flag must survive it while the enables return to their reset values.

// File: rtl/lvd_pkg.sv
package lvd_pkg;
    localparam int REG_W  = 8;
    localparam int B_FLAG = 7;
    localparam int B_ACK  = 6;
    localparam int B_IE   = 5;
    localparam int B_RE   = 4;
    localparam int B_SE   = 3;
    localparam int B_EN   = 2;
    localparam int B_BG   = 0;

    typedef struct packed {
        logic ie;
        logic re;
        logic se;
        logic en;
        logic bg;
    } lvd_cfg_t;

    localparam lvd_cfg_t CFG_RST = '{ie: 1'b0, re: 1'b1, se: 1'b1, en: 1'b1, bg: 1'b0};
endpackage

// File: rtl/lvd_cfg.sv
module lvd_cfg
    import lvd_pkg::*;
#(
    parameter int W = REG_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output lvd_cfg_t     cfg
);
    typedef struct packed {
        lvd_cfg_t cfg;
        logic     locked;
    } cfg_st_t;

    cfg_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.cfg.ie = wr_data[B_IE];
            st_d.cfg.se = wr_data[B_SE];
            st_d.cfg.bg = wr_data[B_BG];
            if (!st_q.locked) begin
                st_d.cfg.en = wr_data[B_EN];
                st_d.cfg.re = wr_data[B_RE];
            end
            st_d.locked = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{cfg: CFG_RST, locked: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg = st_q.cfg;

    // R5
    lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.locked |=> ($stable(st_q.cfg.en) && $stable(st_q.cfg.re)));
endmodule

// File: rtl/lvd_status.sv
module lvd_status (
    input  logic clk,
    input  logic por_n,
    input  logic run,
    input  logic lv_det,
    input  logic cmp_en,
    input  logic ack,
    output logic flag,
    output logic acked
);
    typedef struct packed {
        logic flag;
        logic acked;
    } stat_t;

    stat_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (run) begin
            if (lv_det && cmp_en) begin
                st_d.flag = 1'b1;
            end else if (ack && !lv_det) begin
                st_d.flag = 1'b0;
            end
            if (ack) begin
                st_d.acked = 1'b1;
            end else if (!st_q.flag) begin
                st_d.acked = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag  = st_q.flag;
    assign acked = st_q.acked;

    // R2
    flag_set_chk: assert property (@(posedge clk) disable iff (!por_n)
        (run && lv_det && cmp_en) |=> st_q.flag);
    // R2
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!por_n)
        (st_q.flag && !(run && ack && !lv_det)) |=> st_q.flag);
    // R3
    ack_clear_chk: assert property (@(posedge clk) disable iff (!por_n)
        (run && ack && !lv_det) |=> !st_q.flag);
endmodule

// File: rtl/lvd_req.sv
module lvd_req (
    input  logic clk,
    input  logic rst_n,
    input  logic lv_det,
    input  logic cmp_en,
    input  logic rst_eff,
    output logic req
);
    logic req_d, req_q;

    always_comb begin
        req_d = lv_det && cmp_en && rst_eff;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_q <= 1'b0;
        end else begin
            req_q <= req_d;
        end
    end

    assign req = req_q;
endmodule

// File: rtl/lvd_ctrl_reg.sv
module lvd_ctrl_reg
    import lvd_pkg::*;
(
    input  logic             clk,
    input  logic             por_n,
    input  logic             sys_rst_n,
    input  logic             lv_det,
    input  logic             stop_mode,
    input  logic             test_mode,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    output logic             lvd_irq,
    output logic             lvd_rst_req,
    output logic             cmp_en,
    output logic             bgbuf_en
);
    logic     rst_all_n;
    lvd_cfg_t cfg;
    logic     flag, acked, ack, rst_eff;

    assign rst_all_n = por_n & sys_rst_n;
    assign ack       = wr_en & wr_data[B_ACK];

    lvd_cfg #(.W(REG_W)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_all_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .cfg     (cfg)
    );

    always_comb begin
        cmp_en  = cfg.en && !(stop_mode && !cfg.se);
        rst_eff = cfg.en && cfg.re && !test_mode;
    end

    lvd_status u_status (
        .clk    (clk),
        .por_n  (por_n),
        .run    (sys_rst_n),
        .lv_det (lv_det),
        .cmp_en (cmp_en),
        .ack    (ack),
        .flag   (flag),
        .acked  (acked)
    );

    lvd_req u_req (
        .clk     (clk),
        .rst_n   (rst_all_n),
        .lv_det  (lv_det),
        .cmp_en  (cmp_en),
        .rst_eff (rst_eff),
        .req     (lvd_rst_req)
    );

    always_comb begin
        rd_data         = '0;
        rd_data[B_FLAG] = flag;
        rd_data[B_IE]   = cfg.ie;
        rd_data[B_RE]   = cfg.re;
        rd_data[B_SE]   = cfg.se;
        rd_data[B_EN]   = cfg.en;
        rd_data[B_BG]   = cfg.bg;
        lvd_irq         = flag && cfg.ie && cfg.en && !rst_eff && !acked;
        bgbuf_en        = cfg.bg;
    end

    // R8
    test_no_req_chk: assert property (@(posedge clk) disable iff (!rst_all_n)
        test_mode |=> !lvd_rst_req);
    // R6
    off_no_req_chk: assert property (@(posedge clk) disable iff (!rst_all_n)
        !cfg.en |=> !lvd_rst_req);
    // R3
    ack_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_all_n)
        !rd_data[B_ACK] && !rd_data[1]);
endmodule

// File: tb/lvd_ctrl_reg_tb.sv
module lvd_ctrl_reg_tb;
    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       sys_rst_n = 1'b1;
    logic       lv_det = 1'b0;
    logic       stop_mode = 1'b0;
    logic       test_mode = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       lvd_irq, lvd_rst_req, cmp_en, bgbuf_en;
    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    lvd_ctrl_reg u_dut (
        .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n), .lv_det(lv_det),
        .stop_mode(stop_mode), .test_mode(test_mode), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data), .lvd_irq(lvd_irq),
        .lvd_rst_req(lvd_rst_req), .cmp_en(cmp_en), .bgbuf_en(bgbuf_en)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] d);
        wr_en = 1'b1;
        wr_data = d;
        step();
        wr_en = 1'b0;
        wr_data = 8'h00;
    endtask

    task automatic do_por();
        lv_det = 1'b0; stop_mode = 1'b0; test_mode = 1'b0;
        por_n = 1'b0;
        step(); step();
        por_n = 1'b1;
        step();
    endtask

    task automatic t_reset();
        do_por();
        chk("R1 rd", rd_data, 8'h1C);
        chk("R1 cmp_en", {7'd0, cmp_en}, 8'd1);
        chk("R1 bgbuf", {7'd0, bgbuf_en}, 8'd0);
        chk("R1 irq", {7'd0, lvd_irq}, 8'd0);
        chk("R1 rst_req", {7'd0, lvd_rst_req}, 8'd0);
    endtask

    task automatic t_write_once();
        do_por();
        wr(8'h00);
        chk("R5 first write", rd_data, 8'h00);
        wr(8'h3D);
        chk("R5 second write locked", rd_data, 8'h29);
        chk("R6 cmp off", {7'd0, cmp_en}, 8'd0);
        lv_det = 1'b1;
        step();
        chk("R6 no flag", rd_data, 8'h29);
        chk("R6 no irq", {7'd0, lvd_irq}, 8'd0);
        chk("R6 no rst", {7'd0, lvd_rst_req}, 8'd0);
        lv_det = 1'b0;
    endtask

    task automatic t_ack();
        do_por();
        wr(8'h24);
        chk("R5 accept", rd_data, 8'h24);
        lv_det = 1'b1;
        step();
        chk("R2 flag set", rd_data, 8'hA4);
        chk("R4 irq raised", {7'd0, lvd_irq}, 8'd1);
        chk("R7 no rst when re=0", {7'd0, lvd_rst_req}, 8'd0);
        wr(8'h64);
        chk("R3 ack while low keeps flag", rd_data, 8'hA4);
        chk("R4 ack masks irq", {7'd0, lvd_irq}, 8'd0);
        lv_det = 1'b0;
        step();
        chk("R2 sticky", rd_data, 8'hA4);
        wr(8'h64);
        chk("R3 ack clears", rd_data, 8'h24);
        lv_det = 1'b1;
        step();
        chk("R4 new event irq", {7'd0, lvd_irq}, 8'd1);
        lv_det = 1'b0;
        wr(8'h64);
        chk("R3 clear again", rd_data, 8'h24);
    endtask

    task automatic t_sysrst();
        do_por();
        lv_det = 1'b1;
        step();
        lv_det = 1'b0;
        chk("R2 flag default cfg", rd_data, 8'h9C);
        chk("R7 rst req", {7'd0, lvd_rst_req}, 8'd1);
        chk("R7 irq off", {7'd0, lvd_irq}, 8'd0);
        wr(8'h20);
        chk("R5 write", rd_data, 8'hA0);
        sys_rst_n = 1'b0;
        step();
        sys_rst_n = 1'b1;
        step();
        chk("R10 flag kept", rd_data, 8'h9C);
        wr(8'h04);
        chk("R10 lock reopened", rd_data, 8'h84);
        do_por();
        chk("R10 por clears flag", rd_data, 8'h1C);
    endtask

    task automatic t_prio();
        do_por();
        wr(8'h3C);
        lv_det = 1'b1;
        step();
        chk("R7 reset wins", {7'd0, lvd_rst_req}, 8'd1);
        chk("R7 irq held off", {7'd0, lvd_irq}, 8'd0);
        test_mode = 1'b1;
        step();
        chk("R8 no rst in test", {7'd0, lvd_rst_req}, 8'd0);
        chk("R8 irq in test", {7'd0, lvd_irq}, 8'd1);
        test_mode = 1'b0;
        lv_det = 1'b0;
        step();
    endtask

    task automatic t_stop();
        do_por();
        stop_mode = 1'b1;
        #1;
        chk("R9 stop se=1", {7'd0, cmp_en}, 8'd1);
        @(negedge clk);
        wr(8'h14);
        chk("R9 stop se=0", {7'd0, cmp_en}, 8'd0);
        lv_det = 1'b1;
        step();
        chk("R9 no detect in stop", rd_data, 8'h14);
        stop_mode = 1'b0;
        #1;
        chk("R9 run cmp", {7'd0, cmp_en}, 8'd1);
        @(negedge clk);
        step();
        chk("R9 detect after stop", rd_data, 8'h94);
        lv_det = 1'b0;
    endtask

    task automatic t_bg();
        do_por();
        wr_en = 1'b1;
        wr_data = 8'h5F;
        #1;
        chk("R11 not before edge", rd_data, 8'h1C);
        step();
        wr_en = 1'b0;
        wr_data = 8'h00;
        chk("R11 rd bit1 zero", rd_data, 8'h1D);
        chk("R11 bgbuf", {7'd0, bgbuf_en}, 8'd1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_write_once();
        t_ack();
        t_sysrst();
        t_prio();
        t_stop();
        t_bg();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule